// File: doc/BRIEF.md
# Bus-Mapped 16-Bit Interval Timer

This block is a 16-bit down-counting interval timer that shares a byte-wide register window with a serial controller. Software loads a reload value one byte at a time, then starts and stops the count by reading two command addresses. The read itself is the command; the data it returns is zero. While running, the counter steps down once per pulse on a prescaled tick input. Each time a period elapses it raises a ready flag for the interrupt logic and reloads itself, so the periods repeat until software stops it.

The host port is a single-cycle strobe with a write qualifier, a 4-bit address and 8-bit write data. Read data is registered and appears on the cycle after the strobe. No transfer can be refused, so there is no back-pressure on the host side. Between reads, the read-data output holds its last value. The tick input is a plain enable sampled on each clock edge. The ready flag is a plain level.

Top module: `ctmr_top`

## Requirements
- R1: After reset the reload value and the counter are 0, the timer is stopped, the ready flag is 0 and the read data is 0.
- R2: A write to address 6 replaces only bits 15:8 of the reload value, and a write to address 7 replaces only bits 7:0. The other byte keeps its value.
- R3: A read of address 14 loads the counter from the reload value, starts counting and clears the ready flag. It returns 0.
- R4: A read of address 15 stops counting, clears the ready flag and leaves the counter value unchanged. It returns 0.
- R5: A read of address 6 returns counter bits 15:8, and a read of address 7 returns bits 7:0, taken before that edge's update. A read of any other address returns 0. Read data appears one clock after the strobe and holds until the next read.
- R6: While the timer runs, each clock with the tick input high lowers the counter by one. While it is stopped, ticks leave the counter unchanged.
- R7: A tick that arrives while the counter holds 1 sets the ready flag and reloads the counter from the reload value. The flag then stays set until a start or stop read.
- R8: A reload value of 0 gives a period of 65536 ticks.
- R9: If a start or stop read falls in the same cycle as a tick, the command takes effect and the tick is ignored.
- R10: Writes to addresses 14 and 15, or to any address other than 6 and 7, change neither the reload value, the counter, the run state nor the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Single-cycle access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read, qualified by bus_sel |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| tick_en | input | 1 | Prescaled count enable |
| bus_rdata | output | 8 | Registered read data |
| ctr_ready | output | 1 | Period-elapsed flag |

## Verification
Every result of this block appears one clock after the edge that samples its cause. The ready flag rises after the edge that samples the expiring tick. The counter bytes and the zero returns show on the read data after the edge that samples the read strobe. The bench drives inputs on the falling edge and samples 1 ns after the next rising edge. It compares the flag and the read data against a model that it updates once per driven cycle. Counter state is observed only through reads of addresses 6 and 7, so each read returns the value from before that cycle's tick.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] ADR_HI   = 4'd6;
  localparam logic [ADDR_W-1:0] ADR_LO   = 4'd7;
  localparam logic [ADDR_W-1:0] ADR_GO   = 4'd14;
  localparam logic [ADDR_W-1:0] ADR_HALT = 4'd15;

  typedef enum logic [2:0] {
    CMD_IDLE,
    CMD_WR_HI,
    CMD_WR_LO,
    CMD_GO,
    CMD_HALT,
    CMD_RD_HI,
    CMD_RD_LO,
    CMD_RD_ZERO
  } ctmr_cmd_e;
endpackage

// File: rtl/ctmr_decode.sv
module ctmr_decode
  import ctmr_pkg::*;
(
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output ctmr_cmd_e         cmd
);
  always_comb begin
    cmd = CMD_IDLE;
    if (sel) begin
      if (wr) begin
        if (addr == ADR_HI)      cmd = CMD_WR_HI;
        else if (addr == ADR_LO) cmd = CMD_WR_LO;
        else                     cmd = CMD_IDLE;
      end else begin
        if (addr == ADR_HI)        cmd = CMD_RD_HI;
        else if (addr == ADR_LO)   cmd = CMD_RD_LO;
        else if (addr == ADR_GO)   cmd = CMD_GO;
        else if (addr == ADR_HALT) cmd = CMD_HALT;
        else                       cmd = CMD_RD_ZERO;
      end
    end
  end
endmodule

// File: rtl/ctmr_preset.sv
module ctmr_preset
  import ctmr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  ctmr_cmd_e             cmd,
  input  logic [DATA_W-1:0]     wdata,
  output logic [2*DATA_W-1:0]   preset
);
  localparam int unsigned LANES = 2;

  logic [LANES-1:0] lane_we;
  assign lane_we[0] = (cmd == CMD_WR_LO);
  assign lane_we[1] = (cmd == CMD_WR_HI);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DATA_W-1:0] byte_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          byte_q <= '0;
      else if (lane_we[g]) byte_q <= wdata;
    end
    assign preset[g*DATA_W +: DATA_W] = byte_q;
  end
endmodule

// File: rtl/ctmr_core.sv
module ctmr_core
  import ctmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctmr_cmd_e        cmd,
  input  logic             tick,
  input  logic [CNT_W-1:0] preset,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             expired
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      running <= 1'b0;
      expired <= 1'b0;
    end else begin
      case (cmd)
        CMD_GO: begin
          count   <= preset;
          running <= 1'b1;
          expired <= 1'b0;
        end
        CMD_HALT: begin
          running <= 1'b0;
          expired <= 1'b0;
        end
        default: begin
          if (running && tick) begin
            if (count == ONE) begin
              count   <= preset;
              expired <= 1'b1;
            end else begin
              count <= count - ONE;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ctmr_rdmux.sv
module ctmr_rdmux
  import ctmr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ctmr_cmd_e           cmd,
  input  logic [2*DATA_W-1:0] count,
  output logic [DATA_W-1:0]   rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else begin
      case (cmd)
        CMD_RD_HI:                      rdata <= count[2*DATA_W-1:DATA_W];
        CMD_RD_LO:                      rdata <= count[DATA_W-1:0];
        CMD_GO, CMD_HALT, CMD_RD_ZERO:  rdata <= '0;
        default:                        rdata <= rdata;
      endcase
    end
  end
endmodule

// File: rtl/ctmr_top.sv
module ctmr_top
  import ctmr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [3:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              tick_en,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              ctr_ready
);
  localparam int unsigned CNT_W = 2 * DATA_W;

  ctmr_cmd_e        cmd;
  logic [CNT_W-1:0] preset_q;
  logic [CNT_W-1:0] count_q;
  logic             run_q;

  ctmr_decode u_dec (
    .sel  (bus_sel),
    .wr   (bus_wr),
    .addr (bus_addr),
    .cmd  (cmd)
  );

  ctmr_preset #(.DATA_W(DATA_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd    (cmd),
    .wdata  (bus_wdata),
    .preset (preset_q)
  );

  ctmr_core #(.CNT_W(CNT_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (cmd),
    .tick    (tick_en),
    .preset  (preset_q),
    .count   (count_q),
    .running (run_q),
    .expired (ctr_ready)
  );

  ctmr_rdmux #(.DATA_W(DATA_W)) u_rd (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd   (cmd),
    .count (count_q),
    .rdata (bus_rdata)
  );
endmodule

// File: rtl/ctmr_chk.sv
module ctmr_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [3:0]        bus_addr,
  input logic              tick_en,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              ctr_ready,
  input logic [CNT_W-1:0]  count_q,
  input logic              run_q
);
  logic rd_go, rd_halt, any_cmd;
  assign rd_go   = bus_sel && !bus_wr && (bus_addr == 4'd14);
  assign rd_halt = bus_sel && !bus_wr && (bus_addr == 4'd15);
  assign any_cmd = rd_go || rd_halt;

  // R3
  go_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> (run_q && !ctr_ready && bus_rdata == '0));

  // R4
  halt_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_halt |=> (!run_q && !ctr_ready && bus_rdata == '0 && $stable(count_q)));

  // R6
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick_en && !any_cmd && count_q > CNT_W'(1))
      |=> (count_q == $past(count_q) - CNT_W'(1)));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !rd_go) |=> $stable(count_q));

  // R7
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctr_ready) |-> $past(run_q && tick_en && !any_cmd && count_q == CNT_W'(1)));

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctr_ready && !any_cmd) |=> ctr_ready);
endmodule

bind ctmr_top ctmr_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .tick_en   (tick_en),
  .bus_rdata (bus_rdata),
  .ctr_ready (ctr_ready),
  .count_q   (count_q),
  .run_q     (run_q)
);

// File: tb/sim_ctmr_top.sv
`timescale 1ns/1ps
module sim_ctmr_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       tick_en = 1'b0;
  logic [7:0] bus_rdata;
  logic       ctr_ready;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [15:0] m_pre = '0;
  logic [15:0] m_cnt = '0;
  logic        m_run = 1'b0;
  logic        m_flag = 1'b0;
  logic [7:0]  m_rd = '0;

  always #5 clk = ~clk;

  ctmr_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .tick_en(tick_en),
    .bus_rdata(bus_rdata), .ctr_ready(ctr_ready)
  );

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // model of the requirements, one driven cycle at a time
  task automatic model(bit sel, bit wr, logic [3:0] a, logic [7:0] d, bit tk);
    logic [15:0] old_pre;
    bit go, halt;
    old_pre = m_pre;
    go   = sel && !wr && a == 4'd14;
    halt = sel && !wr && a == 4'd15;
    if (sel && wr && a == 4'd6) m_pre[15:8] = d;
    if (sel && wr && a == 4'd7) m_pre[7:0]  = d;
    if (sel && !wr) begin
      if (a == 4'd6)      m_rd = m_cnt[15:8];
      else if (a == 4'd7) m_rd = m_cnt[7:0];
      else                m_rd = 8'h00;
    end
    if (go) begin
      m_cnt = old_pre; m_run = 1'b1; m_flag = 1'b0;
    end else if (halt) begin
      m_run = 1'b0; m_flag = 1'b0;
    end else if (m_run && tk) begin
      if (m_cnt == 16'd1) begin m_cnt = old_pre; m_flag = 1'b1; end
      else m_cnt = m_cnt - 16'd1;
    end
  endtask

  task automatic step(bit sel, bit wr, logic [3:0] a, logic [7:0] d, bit tk, string tag);
    @(negedge clk);
    bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = d; tick_en = tk;
    model(sel, wr, a, d, tk);
    @(posedge clk);
    #1;
    check(tag, "ctr_ready", {15'd0, ctr_ready}, {15'd0, m_flag});
    check(tag, "bus_rdata", {8'd0, bus_rdata}, {8'd0, m_rd});
  endtask

  task automatic wr_reg(logic [3:0] a, logic [7:0] d, string tag);
    step(1, 1, a, d, 0, tag);
  endtask
  task automatic rd_reg(logic [3:0] a, string tag);
    step(1, 0, a, 8'h00, 0, tag);
  endtask
  task automatic ticks(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 0, 4'd0, 8'h00, 1, tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", "ctr_ready", {15'd0, ctr_ready}, 16'd0);
    check("R1", "bus_rdata", {8'd0, bus_rdata}, 16'd0);
    @(negedge clk); rst_n = 1'b1;
    rd_reg(4'd6, "R1"); rd_reg(4'd7, "R1");
    ticks(3, "R1");
    rd_reg(4'd7, "R1");

    // R2 bytewise reload assembly
    wr_reg(4'd6, 8'h12, "R2"); wr_reg(4'd7, 8'h34, "R2");
    wr_reg(4'd6, 8'hab, "R2");
    rd_reg(4'd14, "R3");
    rd_reg(4'd6, "R2"); rd_reg(4'd7, "R2");
    wr_reg(4'd7, 8'h5c, "R2");
    rd_reg(4'd14, "R3");
    rd_reg(4'd6, "R2"); rd_reg(4'd7, "R2");

    // R5 other read addresses return zero
    rd_reg(4'd3, "R5"); rd_reg(4'd6, "R5"); rd_reg(4'd0, "R5");
    ticks(2, "R5");

    // R6 / R7 short period with reload
    wr_reg(4'd6, 8'h00, "R7"); wr_reg(4'd7, 8'h05, "R7");
    rd_reg(4'd14, "R3");
    ticks(3, "R6"); rd_reg(4'd7, "R6");
    ticks(2, "R7"); rd_reg(4'd7, "R7");
    step(0, 0, 4'd0, 8'h00, 0, "R7");
    ticks(5, "R7"); rd_reg(4'd7, "R7");

    // R4 stop holds count, ticks ignored
    ticks(2, "R4");
    rd_reg(4'd15, "R4");
    ticks(4, "R6"); rd_reg(4'd7, "R4"); rd_reg(4'd6, "R4");

    // R9 command wins over a tick in the same cycle
    step(1, 0, 4'd14, 8'h00, 1, "R9"); rd_reg(4'd7, "R9");
    ticks(4, "R9");
    step(1, 0, 4'd15, 8'h00, 1, "R9"); rd_reg(4'd7, "R9");
    step(1, 0, 4'd14, 8'h00, 0, "R9");
    ticks(4, "R9");
    step(1, 0, 4'd14, 8'h00, 1, "R9"); rd_reg(4'd7, "R9");

    // R10 writes elsewhere have no effect
    wr_reg(4'd14, 8'hff, "R10"); wr_reg(4'd15, 8'hff, "R10"); wr_reg(4'd2, 8'h77, "R10");
    rd_reg(4'd7, "R10"); ticks(1, "R10"); rd_reg(4'd7, "R10");
    rd_reg(4'd14, "R10"); rd_reg(4'd6, "R10"); rd_reg(4'd7, "R10");

    // R8 reload value zero spans 65536 ticks
    wr_reg(4'd6, 8'h00, "R8"); wr_reg(4'd7, 8'h00, "R8");
    rd_reg(4'd14, "R8");
    ticks(1, "R8"); rd_reg(4'd6, "R8"); rd_reg(4'd7, "R8");
    ticks(65534, "R8");
    ticks(1, "R8");
    rd_reg(4'd6, "R8"); rd_reg(4'd7, "R8");
    rd_reg(4'd15, "R8");

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      logic [3:0] a;
      logic [7:0] d;
      r = $urandom_range(0, 99);
      d = 8'($urandom);
      case ($urandom_range(0, 5))
        0: a = 4'd6;
        1: a = 4'd7;
        2: a = 4'd14;
        3: a = 4'd15;
        4: a = 4'd3;
        default: a = 4'd7;
      endcase
      if (a == 4'd6) d = {7'd0, d[0]};
      if (a == 4'd7) d = {2'd0, d[5:0]};
      if (r < 6)       step(1, 1, a, d, $urandom_range(0, 1), "R6");
      else if (r < 14) step(1, 0, (a == 4'd14 && r > 10) ? 4'd7 : a, 8'h00, $urandom_range(0, 1), "R5");
      else             step(0, 0, 4'd0, 8'h00, $urandom_range(0, 3) != 0, "R7");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule